// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves 32-bit words between system memory and a word-wide data FIFO. Software tells it what to move by building a list of four-word descriptors in memory. The engine reads the list base address from a register, fetches one descriptor and checks that the engine owns it. It then streams the descriptor's buffer to or from the FIFO and writes the descriptor's control word back with ownership returned to software. After that it either follows the list to the next descriptor or stops.

A single master port carries every memory access: descriptor fetches, buffer reads, buffer writes and control-word write-backs. A request stays asserted until the memory acknowledges it. The acknowledge may carry an error flag, which stops the engine.

The direction of the transfer comes from the control register. Transmit moves memory to the FIFO, and receive moves the FIFO to memory. Completion and error events collect in a write-one-to-clear status register. Selected events raise an interrupt line.

Top module: `dma_chain_top`

## Requirements
- R1: After reset, `irq`, `mem_req`, `tx_valid` and `rx_ready` are 0, and all four registers read 0.
- R2: A descriptor is four words fetched in order from its address: control word, size word, buffer pointer 1, buffer pointer 2. For a descriptor with control bit 31 (owner) at 1, the engine moves size[15:2] whole words, starting at pointer 1 and stepping the address by 4. Size bits [31:16] are ignored.
- R3: A buffer-1 size of 0 means 65536 bytes, which is 16384 words.
- R4: If control bit 4 (chain) is 1, the next descriptor is fetched from pointer 2. Otherwise it is fetched at the current descriptor address plus 16, or at the list base if control bit 5 (end of ring) is 1. The engine stops after a descriptor with control bit 2 (last) set.
- R5: After a descriptor's buffer is done, its control word is written back to the descriptor address with bit 31 cleared and all other bits unchanged.
- R6: If a fetched descriptor has bit 31 at 0, no data moves, nothing is written back, the engine stops, and status bits 4 (descriptor unavailable) and 9 (abnormal summary) are set.
- R7: Control register bit 3 selects the direction: 0 is transmit (memory to `tx_*`) and 1 is receive (`rx_*` to memory). When a descriptor completes, status bit 0 (transmit) or bit 1 (receive) is set together with bit 8 (normal summary). This does not happen if control bit 1 (interrupt disable) of that descriptor is set.
- R8: An acknowledge with `mem_err` high stops the engine without a write-back, and sets status bits 2 (bus error), 5 (error summary) and 9.
- R9: Status bits are cleared by writing 1 to them. If an event sets a bit in the same cycle that a write clears it, the set wins.
- R10: `irq` is the OR of the status bits that are enabled in the interrupt-enable register. The enable bits use the same positions as the status bits.
- R11: Writing control bit 0 (soft reset) drops any transfer in progress within one cycle. `mem_req`, `tx_valid` and `rx_ready` go low, and the bit reads back 0.
- R12: Register word offsets are 0 for control, 1 for list base, 2 for status and 3 for interrupt enable.
  - Control bits are 0 soft reset, 1 enable/start, 2 fixed burst (stored only) and 3 direction.
  - A write to control with bit 1 set and bit 0 clear starts a walk at the list base.
  - Read data appears one cycle after `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_re` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Error flag, valid with `mem_ack` |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| tx_valid | output | 1 | Transmit word valid |
| tx_ready | input | 1 | FIFO accepts transmit word |
| tx_data | output | 32 | Transmit word |
| rx_valid | input | 1 | Receive word valid |
| rx_ready | output | 1 | Engine accepts receive word |
| rx_data | input | 32 | Receive word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are the wrap of a ring list back to its base and the 64 KiB zero-size buffer.

For the wrap, the bench builds a two-entry ring whose second entry has end-of-ring set but is not marked last. The walk returns to the first entry, which has already been handed back to software by the write-back. The engine must then report the descriptor as unavailable.

For the zero-size case, the memory model returns an address-derived pattern above a threshold address. This lets a full 16384-word transmit be scoreboarded without storing the buffer.

A soft reset is issued while the FIFO holds `tx_ready` low, so that it lands with a word stalled mid-transfer. A bus error is injected on the second word of a buffer.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // register word offsets
  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_BASE = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_IEN  = 2'd3;
  // control register bits
  localparam int CR_RST = 0;
  localparam int CR_EN  = 1;
  localparam int CR_FB  = 2;
  localparam int CR_DIR = 3;
  // status bits
  localparam int ST_W    = 10;
  localparam int ST_TX   = 0;
  localparam int ST_RX   = 1;
  localparam int ST_BUS  = 2;
  localparam int ST_UNAV = 4;
  localparam int ST_ERR  = 5;
  localparam int ST_NORM = 8;
  localparam int ST_ABN  = 9;
  // descriptor control word bits
  localparam int CW_NOINT = 1;
  localparam int CW_LAST  = 2;
  localparam int CW_CHAIN = 4;
  localparam int CW_EOR   = 5;
  localparam int CW_OWN   = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_RD, S_PUSH, S_PULL, S_WR, S_WBACK
  } dstate_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [1:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          ev_tx,
  input  logic          ev_rx,
  input  logic          ev_bus,
  input  logic          ev_unav,
  output logic          start,
  output logic          srst,
  output logic [AW-1:0] list_base,
  output logic          dir,
  output logic          irq
);
  logic            en_r, fb_r;
  logic [ST_W-1:0] status, ien, set_v, clr_v;
  logic            wr_ctrl, wr_base, wr_stat, wr_ien;

  assign wr_ctrl = we && (addr == RA_CTRL);
  assign wr_base = we && (addr == RA_BASE);
  assign wr_stat = we && (addr == RA_STAT);
  assign wr_ien  = we && (addr == RA_IEN);

  always_comb begin
    set_v          = '0;
    set_v[ST_TX]   = ev_tx;
    set_v[ST_RX]   = ev_rx;
    set_v[ST_BUS]  = ev_bus;
    set_v[ST_UNAV] = ev_unav;
    set_v[ST_ERR]  = ev_bus;
    set_v[ST_NORM] = ev_tx | ev_rx;
    set_v[ST_ABN]  = ev_bus | ev_unav;
    clr_v          = wr_stat ? wdata[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srst <= 1'b0; start <= 1'b0; en_r <= 1'b0; fb_r <= 1'b0; dir <= 1'b0;
      list_base <= '0; status <= '0; ien <= '0; irq <= 1'b0; rdata <= '0;
    end else begin
      srst  <= wr_ctrl && wdata[CR_RST];
      start <= wr_ctrl && wdata[CR_EN] && !wdata[CR_RST];
      if (wr_ctrl) begin
        en_r <= wdata[CR_EN];
        fb_r <= wdata[CR_FB];
        dir  <= wdata[CR_DIR];
      end
      if (wr_base) list_base <= wdata[AW-1:0];
      if (wr_ien)  ien <= wdata[ST_W-1:0];
      status <= (status & ~clr_v) | set_v;
      irq    <= |(status & ien);
      if (re) begin
        unique case (addr)
          RA_CTRL: rdata <= {28'd0, dir, fb_r, en_r, srst};
          RA_BASE: rdata <= 32'(list_base);
          RA_STAT: rdata <= 32'(status);
          default: rdata <= 32'(ien);
        endcase
      end
    end
  end

  AST_UNAV_SETS: assert property (@(posedge clk) disable iff (rst)
    ev_unav |=> status[ST_UNAV] && status[ST_ABN]); // R6
  AST_BUS_SETS: assert property (@(posedge clk) disable iff (rst)
    ev_bus |=> status[ST_BUS] && status[ST_ERR] && status[ST_ABN]); // R8
  AST_TXDONE_SETS: assert property (@(posedge clk) disable iff (rst)
    ev_tx |=> status[ST_TX] && status[ST_NORM]); // R7
endmodule

// File: rtl/dma_core.sv
module dma_core
  import dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          srst,
  input  logic          start,
  input  logic          dir,
  input  logic [AW-1:0] list_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [31:0]   tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [31:0]   rx_data,
  output logic          ev_tx,
  output logic          ev_rx,
  output logic          ev_bus,
  output logic          ev_unav
);
  localparam int CNT_W = SIZE_W - 1;

  dstate_t           state;
  logic [1:0]        widx;
  logic [31:0]       cw;
  logic [SIZE_W-1:0] sz1;
  logic [AW-1:0]     ptr1, ptr2, desc_addr, buf_addr, next_desc;
  logic [CNT_W-1:0]  words_left, nwords;
  logic              dir_r;

  always_comb begin
    nwords    = (sz1 == '0) ? (CNT_W'(1) << (SIZE_W - 2)) : CNT_W'(sz1[SIZE_W-1:2]);
    next_desc = cw[CW_CHAIN] ? ptr2 : (cw[CW_EOR] ? list_base : desc_addr + AW'(16));
  end

  always_ff @(posedge clk) begin
    ev_tx <= 1'b0; ev_rx <= 1'b0; ev_bus <= 1'b0; ev_unav <= 1'b0;
    if (rst || srst) begin
      state <= S_IDLE; mem_req <= 1'b0; mem_we <= 1'b0;
      tx_valid <= 1'b0; rx_ready <= 1'b0; widx <= '0; dir_r <= 1'b0;
    end else if (mem_req && mem_ack && mem_err) begin
      ev_bus <= 1'b1; mem_req <= 1'b0; mem_we <= 1'b0; state <= S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          desc_addr <= list_base; dir_r <= dir; widx <= '0;
          mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= list_base; state <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          unique case (widx)
            2'd0: cw   <= mem_rdata;
            2'd1: sz1  <= mem_rdata[SIZE_W-1:0];
            2'd2: ptr1 <= mem_rdata[AW-1:0];
            default: ptr2 <= mem_rdata[AW-1:0];
          endcase
          if (widx == 2'd3) begin
            mem_req <= 1'b0; state <= S_CHECK;
          end else begin
            widx <= widx + 2'd1; mem_addr <= mem_addr + AW'(4);
          end
        end
        S_CHECK: begin
          buf_addr <= ptr1; words_left <= nwords;
          if (!cw[CW_OWN]) begin
            ev_unav <= 1'b1; state <= S_IDLE;
          end else if (nwords == '0) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_addr <= desc_addr;
            mem_wdata <= cw & ~(32'd1 << CW_OWN); state <= S_WBACK;
          end else if (!dir_r) begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= ptr1; state <= S_RD;
          end else begin
            rx_ready <= 1'b1; state <= S_PULL;
          end
        end
        S_RD: if (mem_ack) begin
          mem_req <= 1'b0; tx_valid <= 1'b1; tx_data <= mem_rdata; state <= S_PUSH;
        end
        S_PUSH: if (tx_ready) begin
          tx_valid <= 1'b0; words_left <= words_left - 1'b1; buf_addr <= buf_addr + AW'(4);
          mem_req <= 1'b1;
          if (words_left == CNT_W'(1)) begin
            mem_we <= 1'b1; mem_addr <= desc_addr;
            mem_wdata <= cw & ~(32'd1 << CW_OWN); state <= S_WBACK;
          end else begin
            mem_we <= 1'b0; mem_addr <= buf_addr + AW'(4); state <= S_RD;
          end
        end
        S_PULL: if (rx_valid) begin
          rx_ready <= 1'b0; mem_req <= 1'b1; mem_we <= 1'b1;
          mem_addr <= buf_addr; mem_wdata <= rx_data; state <= S_WR;
        end
        S_WR: if (mem_ack) begin
          words_left <= words_left - 1'b1; buf_addr <= buf_addr + AW'(4);
          if (words_left == CNT_W'(1)) begin
            mem_addr <= desc_addr; mem_wdata <= cw & ~(32'd1 << CW_OWN); state <= S_WBACK;
          end else begin
            mem_req <= 1'b0; mem_we <= 1'b0; rx_ready <= 1'b1; state <= S_PULL;
          end
        end
        default: if (mem_ack) begin
          mem_we <= 1'b0;
          ev_tx <= !cw[CW_NOINT] && !dir_r;
          ev_rx <= !cw[CW_NOINT] && dir_r;
          if (cw[CW_LAST]) begin
            mem_req <= 1'b0; state <= S_IDLE;
          end else begin
            desc_addr <= next_desc; mem_addr <= next_desc; widx <= '0; state <= S_FETCH;
          end
        end
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst || srst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst || srst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R7
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_tx, ev_rx, ev_bus, ev_unav})); // R7
  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    srst |=> !mem_req && !tx_valid && !rx_ready); // R11
endmodule

// File: rtl/dma_chain_top.sv
module dma_chain_top
  import dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [31:0]   tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [31:0]   rx_data,
  output logic          irq
);
  logic          ev_tx, ev_rx, ev_bus, ev_unav, start, srst, dir;
  logic [AW-1:0] list_base;

  dma_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ev_tx(ev_tx), .ev_rx(ev_rx),
    .ev_bus(ev_bus), .ev_unav(ev_unav), .start(start), .srst(srst),
    .list_base(list_base), .dir(dir), .irq(irq)
  );

  dma_core #(.AW(AW), .SIZE_W(SIZE_W)) u_core (
    .clk(clk), .rst(rst), .srst(srst), .start(start), .dir(dir),
    .list_base(list_base), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .ev_tx(ev_tx), .ev_rx(ev_rx),
    .ev_bus(ev_bus), .ev_unav(ev_unav)
  );
endmodule

// File: tb/dma_chain_top_tb.sv
module dma_chain_top_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready = 1'b1, rx_valid = 1'b0, rx_ready, irq;
  logic [31:0] tx_data, rx_data = '0;

  int nchk = 0, nfail = 0, tx_hs = 0;
  logic [31:0] exp_q[$];
  logic [31:0] rx_q[$];
  logic [31:0] mem [0:1023];
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;

  always #2.5 clk = ~clk;

  dma_chain_top u_dut (.*);

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[31:16] ^ a[15:0]};
  endfunction

  // memory model: ack one cycle after a request, pattern above 0x1000
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      mem_err <= mem_req && !mem_ack && err_en && (mem_addr == err_addr);
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          if (mem_addr < 32'h1000) mem[mem_addr[11:2]] <= mem_wdata;
        end else begin
          mem_rdata <= (mem_addr < 32'h1000) ? mem[mem_addr[11:2]] : pat(mem_addr);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor for transmit words
  always @(negedge clk) begin
    if (!rst && tx_valid && tx_ready) begin
      tx_hs++;
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R2 actual=%h expected=<none>", tx_data);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (tx_data !== e) begin
          nfail++;
          $display("FAIL R2 actual=%h expected=%h", tx_data, e);
        end
      end
    end
  end

  // receive source
  initial begin
    forever begin
      @(negedge clk);
      rx_valid = (rx_q.size() != 0);
      if (rx_valid) rx_data = rx_q[0];
      if (rx_valid && rx_ready) begin
        @(posedge clk); #1;
        void'(rx_q.pop_front());
        rx_valid = (rx_q.size() != 0);
        if (rx_valid) rx_data = rx_q[0];
      end
    end
  end

  task automatic push_tx(input logic [31:0] a, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(pat(a + 32'(4 * i)));
  endtask

  task automatic put_desc(input logic [31:0] a, cw, sz, p1, p2);
    mem[a[11:2]] = cw; mem[a[11:2] + 1] = sz;
    mem[a[11:2] + 2] = p1; mem[a[11:2] + 3] = p2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    int q = 0;
    for (int i = 0; i < 100000 && q < 6; i++) begin
      @(negedge clk);
      if (!mem_req && !tx_valid && !rx_ready) q++; else q = 0;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int hs0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEADBEEF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 rx_ready", 32'(rx_ready), 0);
    for (int r = 0; r < 4; r++) begin
      rd(2'(r), d); chk("R1 register", d, 0);
    end

    // R12 register map, fixed burst stored, no start without enable
    wr(2'd0, 32'h4); rd(2'd0, d); chk("R12 ctrl readback", d, 32'h4);
    chk("R12 no start", 32'(mem_req), 0);
    wr(2'd3, 32'h3); rd(2'd3, d); chk("R12 ien readback", d, 32'h3);

    // chained transmit, two descriptors (R2 R4 R5 R7 R10)
    put_desc(32'h100, 32'h8000_001A, 32'h0000_000C, 32'h10000, 32'h200);
    put_desc(32'h200, 32'h8000_0014, 32'h0040_0008, 32'h10100, 32'h0);
    push_tx(32'h10000, 3); push_tx(32'h10100, 2);
    wr(2'd1, 32'h100); rd(2'd1, d); chk("R12 base readback", d, 32'h100);
    wr(2'd0, 32'h2);
    wait_idle();
    chk("R2 all words sent", 32'(exp_q.size()), 0);
    chk("R5 writeback d0", mem[32'h100 >> 2], 32'h0000_001A);
    chk("R5 writeback d1", mem[32'h200 >> 2], 32'h0000_0014);
    rd(2'd2, d); chk("R7 tx done status", d, 32'h101);
    chk("R10 irq set", 32'(irq), 1);

    // R9 write-one-to-clear
    wr(2'd2, 32'h001); rd(2'd2, d); chk("R9 partial clear", d, 32'h100);
    wr(2'd2, 32'h100); rd(2'd2, d); chk("R9 full clear", d, 32'h0);
    chk("R10 irq cleared", 32'(irq), 0);

    // receive (R7)
    put_desc(32'h300, 32'h8000_0014, 32'h8, 32'h800, 32'h0);
    rx_q.push_back(32'hCAFE0001); rx_q.push_back(32'hCAFE0002);
    wr(2'd1, 32'h300); wr(2'd0, 32'hA);
    wait_idle();
    chk("R7 rx word0", mem[32'h800 >> 2], 32'hCAFE0001);
    chk("R7 rx word1", mem[32'h804 >> 2], 32'hCAFE0002);
    chk("R2 rx bound", mem[32'h808 >> 2], 32'hDEADBEEF);
    rd(2'd2, d); chk("R7 rx done status", d, 32'h102);
    wr(2'd2, 32'h3FF);

    // R6 descriptor owned by software
    put_desc(32'h400, 32'h0000_0014, 32'h8, 32'h10000, 32'h0);
    hs0 = tx_hs;
    wr(2'd1, 32'h400); wr(2'd0, 32'h2);
    wait_idle();
    chk("R6 no data", 32'(tx_hs - hs0), 0);
    chk("R6 no writeback", mem[32'h400 >> 2], 32'h0000_0014);
    rd(2'd2, d); chk("R6 unavailable status", d, 32'h210);
    wr(2'd2, 32'h3FF);

    // R4 ring mode wraps to base, then finds it returned to software
    put_desc(32'h500, 32'h8000_0008, 32'h4, 32'h10200, 32'h0);
    put_desc(32'h510, 32'h8000_0020, 32'h4, 32'h10300, 32'h0);
    push_tx(32'h10200, 1); push_tx(32'h10300, 1);
    wr(2'd1, 32'h500); wr(2'd0, 32'h2);
    wait_idle();
    chk("R4 ring words", 32'(exp_q.size()), 0);
    chk("R4 ring wb d1", mem[32'h510 >> 2], 32'h0000_0020);
    rd(2'd2, d); chk("R4 ring wrap status", d, 32'h311);
    wr(2'd2, 32'h3FF);

    // R8 bus error on second buffer word
    put_desc(32'h600, 32'h8000_0014, 32'h10, 32'h10400, 32'h0);
    push_tx(32'h10400, 1);
    err_addr = 32'h10404; err_en = 1'b1;
    wr(2'd1, 32'h600); wr(2'd0, 32'h2);
    wait_idle();
    err_en = 1'b0;
    chk("R8 words before error", 32'(exp_q.size()), 0);
    chk("R8 no writeback", mem[32'h600 >> 2], 32'h8000_0014);
    rd(2'd2, d); chk("R8 error status", d, 32'h224);
    wr(2'd2, 32'h3FF);

    // R11 soft reset with a stalled transmit word
    put_desc(32'h700, 32'h8000_0014, 32'h8, 32'h10500, 32'h0);
    tx_ready = 1'b0;
    wr(2'd1, 32'h700); wr(2'd0, 32'h2);
    for (int i = 0; i < 200 && !tx_valid; i++) @(negedge clk);
    chk("R11 stalled word present", 32'(tx_valid), 1);
    wr(2'd0, 32'h1);
    @(negedge clk);
    chk("R11 tx_valid dropped", 32'(tx_valid), 0);
    chk("R11 mem_req dropped", 32'(mem_req), 0);
    tx_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 stays idle", 32'(tx_valid | mem_req), 0);
    rd(2'd0, d); chk("R11 reset bit reads 0", d, 32'h0);
    chk("R11 no writeback", mem[32'h700 >> 2], 32'h8000_0014);

    // R3 zero size means 64 KiB; buffer-2 size ignored
    put_desc(32'h900, 32'h8000_0014, 32'h0004_0000, 32'h20000, 32'h0);
    push_tx(32'h20000, 16384);
    wr(2'd1, 32'h900); wr(2'd0, 32'h2);
    wait_idle();
    chk("R3 all 16384 words", 32'(exp_q.size()), 0);
    chk("R3 writeback", mem[32'h900 >> 2], 32'h0000_0014);
    rd(2'd2, d); chk("R3 done status", d, 32'h101);

    finish_run();
  end
endmodule